// File: doc/BRIEF.md
# Double-Buffered Eight-Channel Code Bank

This block keeps the settings of eight converter channels, each a 10-bit code, in two stages. The serial front end writes one channel at a time into a staging register. A second, active register per channel drives the converter code. The block decides when staged values move into the active stage.

Three conditions cause that transfer. The first is an external load pin that is held low. The second is the falling edge of that pin. The third is a latch flag that arrives with a written word. Resets bypass all of this and set values directly. A full reset sets every channel to mid-scale in both stages. A per-channel reset sets one channel to mid-scale in both stages. Reads return the staged value, not the active one.

The load pin is asynchronous. It passes through a two-stage synchroniser before the block uses it.

Top module: `dual_stage_code_bank`

## Requirements
- R1: After `rst_n` is released, every channel holds code 512 in both the staged and the active stage.
- R2: A cycle with `wr_en` high stores `wr_code` into the staged register selected by `wr_chan`. `rd_code` shows the staged register selected by `rd_chan` combinationally, even when that value differs from the active code.
- R3: While the synchronised load level is low, a write reaches the active code of its channel at the same clock edge that stores it.
- R4: While the synchronised load level is high, a write whose `wr_latch` is 0 leaves every active code unchanged.
- R5: When `load_n` falls, all eight active codes take their staged values at the third rising clock edge after the fall, and not before.
- R6: While the synchronised load level is high, a write with `wr_latch` = 1 copies all eight staged registers, including the word just written, into the active stage at the edge that stores the word.
- R7: `full_rst` sets both stages of all channels to 512 at the next edge, whatever the load level. It overrides any write in the same cycle.
- R8: `chan_rst` sets both stages of channel `chan_rst_idx` to 512 at the next edge, whatever the load level. It overrides a write to the same channel in the same cycle and leaves the other channels unchanged.
- R9: A write with `wr_latch` = 1 while the load level is low has the same effect as a plain write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| wr_en | input | 1 | Write strobe for one staged register |
| wr_chan | input | 3 | Channel index of the write |
| wr_code | input | 10 | Code to store |
| wr_latch | input | 1 | Latch-all flag carried with the write |
| load_n | input | 1 | Asynchronous load pin: low means transfer |
| full_rst | input | 1 | Full reset request (general call) |
| chan_rst | input | 1 | Reset request for one channel |
| chan_rst_idx | input | 3 | Channel index for `chan_rst` |
| rd_chan | input | 3 | Channel index for readback |
| rd_code | output | 10 | Staged code of channel `rd_chan` |
| active_codes | output | 80 | Active codes; channel n is in bits [10n+9:10n] |

## Verification
A staged register that is corrupted shows up at `rd_code` as soon as that channel is selected. It stays invisible at `active_codes` until the next transfer, so the bench reads both stages after each stimulus. A wrong synchroniser depth or a wrong edge detect moves the transfer away from the third edge after the pin falls, which the bench samples exactly. A priority error between a reset and a write changes only the collided channel at the next edge. For that reason the neighbouring channels are checked as well.

// File: rtl/dual_stage_code_bank.sv
module dual_stage_code_bank #(
  parameter int NCH = 8,
  parameter int W   = 10,
  localparam int IW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_chan,
  input  logic [W-1:0]    wr_code,
  input  logic            wr_latch,
  input  logic            load_n,
  input  logic            full_rst,
  input  logic            chan_rst,
  input  logic [IW-1:0]   chan_rst_idx,
  input  logic [IW-1:0]   rd_chan,
  output logic [W-1:0]    rd_code,
  output logic [NCH*W-1:0] active_codes
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  logic [W-1:0] stage_q [NCH];
  logic [W-1:0] act_q   [NCH];
  logic [W-1:0] stage_d [NCH];
  logic         ld_s1, ld_s2;
  logic         follow;

  assign follow = !ld_s2 || (wr_en && wr_latch);

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      stage_d[c] = stage_q[c];
      if (chan_rst && chan_rst_idx == IW'(c))
        stage_d[c] = MID;
      else if (wr_en && wr_chan == IW'(c))
        stage_d[c] = wr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_s1 <= 1'b1;
      ld_s2 <= 1'b1;
      for (int c = 0; c < NCH; c++) begin
        stage_q[c] <= MID;
        act_q[c]   <= MID;
      end
    end else begin
      ld_s1 <= load_n;
      ld_s2 <= ld_s1;
      for (int c = 0; c < NCH; c++) begin
        if (full_rst) begin
          stage_q[c] <= MID;
          act_q[c]   <= MID;
        end else begin
          stage_q[c] <= stage_d[c];
          if (follow)
            act_q[c] <= stage_d[c];
          else if (chan_rst && chan_rst_idx == IW'(c))
            act_q[c] <= MID;
        end
      end
    end
  end

  assign rd_code = stage_q[rd_chan];

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign active_codes[g*W +: W] = act_q[g];
  end
endmodule

// File: rtl/dual_stage_code_bank_chk.sv
module dual_stage_code_bank_chk #(
  parameter int NCH = 8,
  parameter int W   = 10,
  localparam int IW = $clog2(NCH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IW-1:0]    wr_chan,
  input logic [W-1:0]     wr_code,
  input logic             wr_latch,
  input logic             full_rst,
  input logic             chan_rst,
  input logic [IW-1:0]    chan_rst_idx,
  input logic [NCH*W-1:0] active_codes,
  input logic             ld_sync
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);
  logic [W-1:0] act [NCH];
  for (genvar g = 0; g < NCH; g++) begin : g_sl
    assign act[g] = active_codes[g*W +: W];
  end

  // R7
  full_reset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst |=> active_codes == {NCH{MID}});

  // R8
  chan_reset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_rst && !full_rst) |=> act[$past(chan_rst_idx)] == MID);

  // R4
  hold_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sync && !(wr_en && wr_latch) && !full_rst && !chan_rst) |=> $stable(active_codes));

  // R3
  direct_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_sync && wr_en && !full_rst && !chan_rst) |=> act[$past(wr_chan)] == $past(wr_code));

  // R6
  flag_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sync && wr_en && wr_latch && !full_rst && !chan_rst) |=> act[$past(wr_chan)] == $past(wr_code));
endmodule

bind dual_stage_code_bank dual_stage_code_bank_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_code(wr_code),
  .wr_latch(wr_latch), .full_rst(full_rst), .chan_rst(chan_rst),
  .chan_rst_idx(chan_rst_idx), .active_codes(active_codes), .ld_sync(ld_s2)
);

// File: tb/tb_dual_stage_code_bank.sv
module tb_dual_stage_code_bank;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_latch = 0, load_n = 1, full_rst = 0, chan_rst = 0;
  logic [2:0] wr_chan = 0, chan_rst_idx = 0, rd_chan = 0;
  logic [9:0] wr_code = 0, rd_code;
  logic [79:0] active_codes;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_stage_code_bank dut (.*);

  // {pin, flag, chan, code, expected active of chan}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 1'b0, 3'd0, 10'd100,  10'd100},
    {1'b0, 1'b0, 3'd7, 10'd1023, 10'd1023},
    {1'b0, 1'b1, 3'd3, 10'd0,    10'd0},
    {1'b1, 1'b0, 3'd1, 10'd200,  10'd512},
    {1'b1, 1'b0, 3'd2, 10'd300,  10'd512},
    {1'b1, 1'b1, 3'd4, 10'd400,  10'd400},
    {1'b1, 1'b0, 3'd5, 10'd55,   10'd512},
    {1'b0, 1'b0, 3'd6, 10'd66,   10'd66}
  };

  function automatic logic [9:0] act(input int ch);
    return active_codes[ch*10 +: 10];
  endfunction

  task automatic check(input string req, input int actual, input int expv);
    checks++;
    if (actual != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expv);
    end
  endtask

  task automatic rd(input int ch, output logic [9:0] v);
    rd_chan = 3'(ch);
    #1 v = rd_code;
  endtask

  task automatic write(input int ch, input int code, input bit flag);
    @(negedge clk);
    wr_en = 1; wr_chan = 3'(ch); wr_code = 10'(code); wr_latch = flag;
    @(negedge clk);
    wr_en = 0; wr_latch = 0;
  endtask

  task automatic set_pin(input bit lvl);
    @(negedge clk);
    load_n = lvl;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [9:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      check("R1 active", act(c), 512);
      rd(c, v);
      check("R1 staged", v, 512);
    end

    foreach (VEC[i]) begin
      set_pin(VEC[i][24]);
      write(VEC[i][22:20], VEC[i][19:10], VEC[i][23]);
      check(VEC[i][23] ? (VEC[i][24] ? "R6 flag write" : "R9 flag while low")
                       : (VEC[i][24] ? "R4 hold" : "R3 direct"),
            act(VEC[i][22:20]), VEC[i][9:0]);
      rd(VEC[i][22:20], v);
      check("R2 readback", v, VEC[i][19:10]);
    end
    check("R6 flag copies ch1", act(1), 200);
    check("R6 flag copies ch2", act(2), 300);
    check("R5 fall copies ch5", act(5), 55);

    // R5 timing: transfer exactly at the third edge
    set_pin(1);
    write(0, 777, 0);
    rd(0, v);
    check("R2 staged differs from active", v, 777);
    check("R4 hold ch0", act(0), 100);
    @(negedge clk); load_n = 0;
    @(negedge clk); check("R5 edge1", act(0), 100);
    @(negedge clk); check("R5 edge2", act(0), 100);
    @(negedge clk); check("R5 edge3", act(0), 777);

    // R8 with same-channel write collision, pin high
    write(3, 900, 0);
    write(4, 901, 0);
    set_pin(1);
    @(negedge clk);
    chan_rst = 1; chan_rst_idx = 3; wr_en = 1; wr_chan = 3; wr_code = 5;
    @(negedge clk);
    chan_rst = 0; wr_en = 0;
    check("R8 active ch3", act(3), 512);
    rd(3, v);
    check("R8 staged ch3", v, 512);
    check("R8 neighbour ch4", act(4), 901);

    // R7 with write collision, pin high
    write(2, 11, 0);
    @(negedge clk);
    full_rst = 1; wr_en = 1; wr_chan = 2; wr_code = 22; wr_latch = 1;
    @(negedge clk);
    full_rst = 0; wr_en = 0; wr_latch = 0;
    for (int c = 0; c < 8; c++) begin
      check("R7 active", act(c), 512);
      rd(c, v);
      check("R7 staged", v, 512);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule